// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog for a processor subsystem. A free-running prescaler divides the system clock into a slow tick. Once software has enabled the watchdog, an up-counter advances on each tick. If software never reloads the counter, it overflows past its top value. On overflow the block drives a reset pulse of fixed length into the chip's reset network and sets a sticky flag. After reset, software reads that flag to tell a watchdog reset from a pin reset.

Software services the watchdog by writing a fresh value into the counter. That value sets how many ticks remain before overflow. The counter can be read or written at any moment. Control fields are harder to change by accident. Each field has an inhibit bit beside it, and a write alters the field only if that inhibit bit is written as 0 in the same access. The enable field and the flag-clear action also need a global unlock bit that is already set.

Top module: `wdog_guard`

## Requirements
- R1: After the reset pin (`rst_n` low), the counter reads 0x00 and `wdt_rst` is 0. The control register reads 0x2A: flag bit0=0, enable bit2=0, unlock bit4=0, and the inhibit bits 1, 3 and 5 always read 1. Bits 7:6 read 0.
- R2: Address 1 is the counter. A bus write to it loads `bus_wdata` regardless of the unlock or enable state, and a read returns the current value.
- R3: While enable (control bit2) is 1, the counter increments once every PRESCALE clocks. While enable is 0, the counter holds its value and `wdt_rst` stays low.
- R4: A tick that arrives while the counter holds 0xFF with enable set wraps the counter to 0x00. In the same clock it sets the flag (bit0) and starts the reset pulse.
- R5: `wdt_rst` stays high for exactly PULSE_LEN consecutive clocks after an overflow.
- R6: A control write (address 0) changes enable to wdata[2] only if unlock is already 1 and wdata[3] is 0. Otherwise enable is unchanged.
- R7: A control write changes unlock to wdata[4] only if wdata[5] is 0.
- R8: The flag is cleared by a control write with wdata[0]=0 and wdata[1]=0 while unlock is 1. Software can never set the flag, and a write with wdata[1]=1 leaves it unchanged.
- R9: The flag stays set through and after the watchdog's own reset pulse, and only the reset pin or R8 clears it.
- R10: A counter write that lands on a tick clock takes the written value and the tick is lost. Writes never restart the prescaler, so tick spacing is unaffected.
- R11: After the counter is loaded with value V, overflow occurs on the (256−V)-th following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset pin |
| bus_we | input | 1 | Bus write strobe for one clock |
| bus_addr | input | 1 | 0 selects control/status, 1 selects counter |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| wdt_rst | output | 1 | Internal reset pulse request |

## Verification
The bench sets a short prescale and a short pulse length. It measures tick spacing by watching counter changes, which catches a prescaler that restarts on a write: the next tick after a mid-period reload then comes late. It places a reload exactly on a tick clock; a design that lets the increment win reads one above the written value. It sends guarded writes with each inhibit bit set and with unlock clear, and expects those fields unchanged; a design that ignores the guards would arm or clear the watchdog by accident. It counts the ticks and the pulse width of an overflow from a near-top reload, and checks that the flag survives the pulse but not the pin.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int REG_W = 8;

  // control/status field positions
  localparam int B_FLAG     = 0;
  localparam int B_FLAG_INH = 1;
  localparam int B_EN       = 2;
  localparam int B_EN_INH   = 3;
  localparam int B_UNL      = 4;
  localparam int B_UNL_INH  = 5;

  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_CNT = 1'b1;

  // control register read image; inhibit bits always read as one
  function automatic logic [REG_W-1:0] ctl_pack(input logic flag,
                                                input logic en,
                                                input logic unl);
    logic [REG_W-1:0] v;
    v = '0;
    v[B_FLAG]     = flag;
    v[B_FLAG_INH] = 1'b1;
    v[B_EN]       = en;
    v[B_EN_INH]   = 1'b1;
    v[B_UNL]      = unl;
    v[B_UNL_INH]  = 1'b1;
    return v;
  endfunction

  // a guarded field may change when the gate is open and its inhibit is zero
  function automatic logic field_ok(input logic wr, input logic gate,
                                    input logic inhibit);
    return wr & gate & ~inhibit;
  endfunction

  // ticks left before overflow from a loaded value
  function automatic int ticks_left(input int load, input int width);
    return (1 << width) - load;
  endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV = 8192
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      logic [PW-1:0] pre_q;
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic step;
  assign step = tick & en & ~load;
  assign ovf  = step & (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [5:0] wd,
  input  logic       ovf,
  output logic       flag,
  output logic       en,
  output logic       unl
);
  logic unl_wr, en_wr, flag_clr;

  assign unl_wr   = field_ok(wr, 1'b1, wd[B_UNL_INH]);
  assign en_wr    = field_ok(wr, unl, wd[B_EN_INH]);
  assign flag_clr = field_ok(wr, unl, wd[B_FLAG_INH]) & ~wd[B_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl  <= 1'b0;
      en   <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (unl_wr) unl <= wd[B_UNL];
      if (en_wr)  en  <= wd[B_EN];
      if (ovf)           flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int LW = $clog2(LEN + 1);
  localparam logic [LW-1:0] LOAD = LW'(LEN);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left_q <= '0;
    else if (fire)        left_q <= LOAD;
    else if (left_q != 0) left_q <= left_q - 1'b1;
  end

  assign pulse = (left_q != 0);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int PRESCALE  = 8192,
  parameter int PULSE_LEN = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             wdt_rst
);
  logic             tick_w;
  logic             ovf_w;
  logic             cnt_wr_w;
  logic             ctl_wr_w;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q, en_q, unl_q;

  assign cnt_wr_w = bus_we & (bus_addr == ADDR_CNT);
  assign ctl_wr_w = bus_we & (bus_addr == ADDR_CTL);

  wdog_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick_w)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .en(en_q),
    .load(cnt_wr_w), .load_val(bus_wdata[CNT_W-1:0]),
    .cnt(cnt_q), .ovf(ovf_w)
  );

  wdog_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr_w), .wd(bus_wdata[5:0]),
    .ovf(ovf_w), .flag(flag_q), .en(en_q), .unl(unl_q)
  );

  wdog_pulse #(.LEN(PULSE_LEN)) u_pls (
    .clk(clk), .rst_n(rst_n), .fire(ovf_w), .pulse(wdt_rst)
  );

  assign bus_rdata = (bus_addr == ADDR_CNT) ? REG_W'(cnt_q)
                                            : ctl_pack(flag_q, en_q, unl_q);
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 512
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ovf,
  input logic             bus_we,
  input logic             bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [CNT_W-1:0] cnt,
  input logic             flag,
  input logic             en,
  input logic             unl,
  input logic             rst_out
);
  logic [31:0] hi_run;
  logic        sw_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_run <= '0;
    else if (rst_out) hi_run <= hi_run + 1;
    else              hi_run <= '0;
  end

  assign sw_clr = bus_we & ~bus_addr & unl & ~bus_wdata[1] & ~bus_wdata[0];

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !(bus_we && bus_addr)) |=> $stable(cnt));

  assert_ovf_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (tick && en));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == '0 && flag && rst_out));

  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> (hi_run == PULSE_LEN));

  assert_en_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && !bus_addr && unl && !bus_wdata[3]) |=> $stable(en));

  assert_unl_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && !bus_addr && !bus_wdata[5]) |=> $stable(unl));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !sw_clr) |=> flag);

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr) |=> (cnt == $past(bus_wdata[CNT_W-1:0])));
endmodule

bind wdog_guard wdog_guard_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .ovf(ovf_w),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .cnt(cnt_q), .flag(flag_q), .en(en_q), .unl(unl_q), .rst_out(wdt_rst)
);

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;
  localparam int DIV = 16;
  localparam int PLEN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       wdt_rst;

  always #10 clk = ~clk;

  wdog_guard #(.CNT_W(8), .PRESCALE(DIV), .PULSE_LEN(PLEN)) u_wdog_guard (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
  );

  typedef struct {
    int    act;
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;

  // monitor: pops scoreboard items and compares
  always @(posedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (it.act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got 0x%0h expected 0x%0h", it.tag, it.act, it.exp);
      end
    end
  end

  task automatic push(input int act, input int exp, input string tag);
    item_t it;
    it.act = act; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  function automatic logic [7:0] ctl_img(input bit f, input bit e, input bit u);
    return {2'b00, 1'b1, u, 1'b1, e, 1'b1, f};
  endfunction

  // called at a negedge; write lands at the next posedge
  task automatic wr(input logic a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic chk_reg(input logic a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd(a, v);
    push(v, exp, tag);
  endtask

  task automatic wait_change(output int cyc);
    logic [7:0] p, v;
    rd(1'b1, p);
    cyc = 0;
    do begin
      @(negedge clk); cyc++;
      rd(1'b1, v);
    end while (v == p && cyc < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_reg(1'b0, 8'h2A, "R1 ctl");
    chk_reg(1'b1, 8'h00, "R1 cnt");
    push(wdt_rst, 0, "R1 wdt_rst");
    rst_n = 1'b1;
    @(negedge clk);

    // R6 enable with unlock clear is ignored; R3 counter holds while off
    wr(1'b0, 8'h26);
    chk_reg(1'b0, 8'h2A, "R6 locked enable");
    repeat (40) @(negedge clk);
    chk_reg(1'b1, 8'h00, "R3 hold off");

    // R7 unlock guarded only by its inhibit
    wr(1'b0, 8'h1A);
    chk_reg(1'b0, ctl_img(0, 0, 1), "R7 unlock set");
    wr(1'b0, 8'h2A);
    chk_reg(1'b0, ctl_img(0, 0, 1), "R7 inhibited");

    // R6 enable inhibited, then allowed
    wr(1'b0, 8'h3E);
    chk_reg(1'b0, ctl_img(0, 0, 1), "R6 inhibited");
    wr(1'b0, 8'h36);
    chk_reg(1'b0, ctl_img(0, 1, 1), "R6 enable");

    // R2 counter write and read back
    wr(1'b1, 8'h10);
    chk_reg(1'b1, 8'h10, "R2 readback");

    // R3 spacing of ticks
    wait_change(c);
    wait_change(c);
    push(c, DIV, "R3 spacing a");
    wait_change(c);
    push(c, DIV, "R3 spacing b");

    // R10 mid-period write keeps prescaler phase
    repeat (4) @(negedge clk);
    wr(1'b1, 8'h40);
    chk_reg(1'b1, 8'h40, "R2 mid write");
    wait_change(c);
    push(c, DIV - 5, "R10 phase kept");
    chk_reg(1'b1, 8'h41, "R3 increment");

    // R10 write on the tick clock wins
    repeat (DIV - 1) @(negedge clk);
    wr(1'b1, 8'h80);
    chk_reg(1'b1, 8'h80, "R10 write wins");
    wait_change(c);
    push(c, DIV, "R10 next tick");
    chk_reg(1'b1, 8'h81, "R10 after");

    // R11 / R4 / R5 overflow from 0xFD
    begin
      int chg, hi;
      logic [7:0] p;
      wr(1'b1, 8'hFD);
      rd(1'b1, p);
      chg = 0;
      for (int i = 0; i < 10 * DIV && !wdt_rst; i++) begin
        @(negedge clk);
        rd(1'b1, v);
        if (v != p) begin chg++; p = v; end
      end
      push(chg, 3, "R11 ticks to overflow");
      chk_reg(1'b1, 8'h00, "R4 wrap");
      chk_reg(1'b0, ctl_img(1, 1, 1), "R4 flag set");
      hi = 0;
      while (wdt_rst && hi < 100) begin hi++; @(negedge clk); end
      push(hi, PLEN, "R5 pulse length");
    end

    // R9 flag survives pulse
    chk_reg(1'b0, ctl_img(1, 1, 1), "R9 sticky");
    // R8 clear guarded by inhibit
    wr(1'b0, 8'h3E);
    chk_reg(1'b0, ctl_img(1, 1, 1), "R8 inhibited clear");
    wr(1'b0, 8'h3C);
    chk_reg(1'b0, ctl_img(0, 1, 1), "R8 clear");
    wr(1'b0, 8'h3D);
    chk_reg(1'b0, ctl_img(0, 1, 1), "R8 no sw set");

    // R3 disabled: no count, no reset
    wr(1'b0, 8'h32);
    chk_reg(1'b0, ctl_img(0, 0, 1), "R6 disable");
    wr(1'b1, 8'hFF);
    begin
      int seen;
      seen = 0;
      repeat (3 * DIV) begin @(negedge clk); if (wdt_rst) seen = 1; end
      push(seen, 0, "R3 no reset when off");
    end
    chk_reg(1'b1, 8'hFF, "R3 hold at top");

    // R9 pin reset clears flag
    wr(1'b0, 8'h36);
    begin
      int k;
      k = 0;
      while (!wdt_rst && k < 4 * DIV) begin @(negedge clk); k++; end
    end
    chk_reg(1'b0, ctl_img(1, 1, 1), "R4 flag again");
    rst_n = 1'b0;
    @(negedge clk);
    chk_reg(1'b0, 8'h2A, "R9 pin clears flag");
    push(wdt_rst, 0, "R9 pulse cleared");
    rst_n = 1'b1;

    repeat (3) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule